// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block decides which of three power modes a small controller is in: full run, a light sleep with the processor halted, and a deep off state. The processor asks for a mode by writing request bits through a simple write port. The block then drives the enables that gate the processor clock, the peripheral clocks and the internal supply nets, and a hold signal that keeps the I/O pins at their last value while the supply is off.

The light sleep is left as soon as any interrupt is pending. The deep off state works differently. The processor must first set a separate arming bit, and then write the stop request in a later cycle. Once in the deep off state, interrupts have no effect. Only an external reset-pin event or a power-on event brings the block back. It then drives a system reset for a fixed number of cycles and returns to run mode with the arming bit cleared.

A reset event that arrives in run or sleep mode goes through the same recovery pulse. Write strobes are accepted only in run mode.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst`, and whenever the block is in run mode, `core_clk_en`, `periph_clk_en` and `pwr_net_en` are 1, and `pin_hold` and `sys_rst_out` are 0.
- R2: In run mode, a `ctl_we` pulse with `ctl_idle`=1 puts the block in sleep from the next cycle. In sleep, `core_clk_en`=0 while `periph_clk_en` and `pwr_net_en` stay 1.
- R3: In sleep, a clock edge that samples `irq_pend`=1 returns the block to run mode.
- R4: A write with `ctl_stop`=1 while `arm_state`=0 leaves the block in run mode. This includes the case where the arming bit is written in the same cycle as the stop request.
- R5: A write with `ctl_stop`=1 while `arm_state`=1 enters the deep off state on the next edge. There all three enables are 0 and `pin_hold`=1.
- R6: In the deep off state, `irq_pend` has no effect; the block stays off.
- R7: An edge that samples `pin_rst_evt` or `por_evt` starts recovery. `sys_rst_out` is then 1 for exactly 16 cycles (parameter `RST_CYCLES`), after which the block is in run mode with `arm_state`=0.
- R8: If one write sets both `ctl_idle` and `ctl_stop` while armed, the block enters the deep off state, not sleep.
- R9: If `irq_pend` is already 1 when sleep is requested, `mode_status` reads 1 for exactly one cycle and then 0.
- R10: `arm_state` follows `arm_wdata` on an `arm_we` write in run mode. It stays set across sleep entry and exit, and it clears only by a write or by a reset event.
- R11: `mode_status` encodes run as 0, sleep as 1 and deep off as 2. During recovery it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high register initialisation |
| ctl_we | input | 1 | Write strobe for the mode request bits |
| ctl_idle | input | 1 | Sleep request bit |
| ctl_stop | input | 1 | Deep off request bit |
| arm_we | input | 1 | Write strobe for the arming bit |
| arm_wdata | input | 1 | New value of the arming bit |
| irq_pend | input | 1 | Any interrupt pending |
| pin_rst_evt | input | 1 | Reset-pin event |
| por_evt | input | 1 | Power-on reset event |
| core_clk_en | output | 1 | Processor clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| pwr_net_en | output | 1 | Internal supply net enable |
| pin_hold | output | 1 | Freeze I/O pin state |
| sys_rst_out | output | 1 | System reset during recovery |
| mode_status | output | 2 | Current mode code |
| arm_state | output | 1 | Arming bit value |

## Verification
Two pairs of functions can fall in the same cycle. The first is a sleep request and a stop request: the bench arms the block, writes both bits in one strobe, and expects the deep off code rather than the sleep code. The second is a sleep request and a wake condition: the bench raises `irq_pend` before the sleep write and requires `mode_status` to read 1 at the next sample and 0 at the one after. A third clash is an arming write and a stop in the same strobe cycle. There the bench expects the stop to be refused, because the arming bit must already be set.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_IDLE  = 2'd1,
        PM_OFF   = 2'd2,
        PM_RECOV = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic core_en;
        logic periph_en;
        logic net_en;
        logic hold;
        logic sysrst;
    } pm_ctl_t;

    function automatic pm_ctl_t ctl_of(pm_state_e s);
        pm_ctl_t c;
        unique case (s)
            PM_RUN:   c = '{core_en: 1'b1, periph_en: 1'b1, net_en: 1'b1, hold: 1'b0, sysrst: 1'b0};
            PM_IDLE:  c = '{core_en: 1'b0, periph_en: 1'b1, net_en: 1'b1, hold: 1'b0, sysrst: 1'b0};
            PM_OFF:   c = '{core_en: 1'b0, periph_en: 1'b0, net_en: 1'b0, hold: 1'b1, sysrst: 1'b0};
            default:  c = '{core_en: 1'b1, periph_en: 1'b1, net_en: 1'b1, hold: 1'b0, sysrst: 1'b1};
        endcase
        return c;
    endfunction

    function automatic logic [1:0] status_of(pm_state_e s);
        return (s == PM_RECOV) ? 2'd0 : 2'(s);
    endfunction

endpackage

// File: rtl/pwrseq_rst_timer.sv
module pwrseq_rst_timer #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (RST_CYCLES > 2) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (start) begin
            cnt_q <= '0;
            act_q <= 1'b1;
        end else if (act_q) begin
            if (cnt_q == LAST) begin
                act_q <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy = act_q;
    assign done = act_q && (cnt_q == LAST);

    // R7
    timer_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !act_q |-> cnt_q == '0);

endmodule

// File: rtl/pwrseq_mode_fsm.sv
module pwrseq_mode_fsm
    import pwrseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctl_we,
    input  logic      ctl_idle,
    input  logic      ctl_stop,
    input  logic      arm_we,
    input  logic      arm_wdata,
    input  logic      irq_pend,
    input  logic      rst_evt,
    input  logic      tmr_done,
    output pm_state_e state_o,
    output logic      arm_o,
    output logic      tmr_start
);
    pm_state_e st_q, st_d;
    logic      arm_q, arm_d;
    logic      in_run;

    assign in_run = (st_q == PM_RUN);

    always_comb begin
        st_d = st_q;
        if (rst_evt) begin
            st_d = PM_RECOV;
        end else begin
            unique case (st_q)
                PM_RUN: begin
                    if (ctl_we && ctl_stop && arm_q) st_d = PM_OFF;
                    else if (ctl_we && ctl_idle)     st_d = PM_IDLE;
                end
                PM_IDLE:  if (irq_pend) st_d = PM_RUN;
                PM_OFF:   st_d = PM_OFF;
                default:  if (tmr_done) st_d = PM_RUN;
            endcase
        end
    end

    always_comb begin
        arm_d = arm_q;
        if (rst_evt)               arm_d = 1'b0;
        else if (in_run && arm_we) arm_d = arm_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PM_RUN;
            arm_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            arm_q <= arm_d;
        end
    end

    assign state_o   = st_q;
    assign arm_o     = arm_q;
    assign tmr_start = rst_evt;

    // R3
    idle_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PM_IDLE && irq_pend && !rst_evt) |=> st_q == PM_RUN);
    // R4
    stop_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && ctl_we && ctl_stop && !ctl_idle && !arm_q && !rst_evt) |=> st_q == PM_RUN);
    // R6
    off_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PM_OFF && !rst_evt) |=> st_q == PM_OFF);
    // R8
    stop_over_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (in_run && ctl_we && ctl_stop && ctl_idle && arm_q && !rst_evt) |=> st_q == PM_OFF);
    // R7
    recov_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PM_RECOV && !tmr_done && !rst_evt) |=> st_q == PM_RECOV);
    // R7
    recov_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PM_RECOV && tmr_done && !rst_evt) |=> (st_q == PM_RUN && !arm_q));
    // R10
    arm_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (arm_q && !arm_we && !rst_evt) |=> arm_q);

endmodule

// File: rtl/pwrseq_out_decode.sv
module pwrseq_out_decode
    import pwrseq_pkg::*;
(
    input  pm_state_e   state,
    output pm_ctl_t     ctl,
    output logic [1:0]  status
);
    assign ctl    = ctl_of(state);
    assign status = status_of(state);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwrseq_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic       ctl_idle,
    input  logic       ctl_stop,
    input  logic       arm_we,
    input  logic       arm_wdata,
    input  logic       irq_pend,
    input  logic       pin_rst_evt,
    input  logic       por_evt,
    output logic       core_clk_en,
    output logic       periph_clk_en,
    output logic       pwr_net_en,
    output logic       pin_hold,
    output logic       sys_rst_out,
    output logic [1:0] mode_status,
    output logic       arm_state
);
    pm_state_e st;
    pm_ctl_t   ctl;
    logic      rst_evt, tmr_start, tmr_busy, tmr_done;

    assign rst_evt = pin_rst_evt | por_evt;

    pwrseq_mode_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl_we    (ctl_we),
        .ctl_idle  (ctl_idle),
        .ctl_stop  (ctl_stop),
        .arm_we    (arm_we),
        .arm_wdata (arm_wdata),
        .irq_pend  (irq_pend),
        .rst_evt   (rst_evt),
        .tmr_done  (tmr_done),
        .state_o   (st),
        .arm_o     (arm_state),
        .tmr_start (tmr_start)
    );

    pwrseq_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .busy  (tmr_busy),
        .done  (tmr_done)
    );

    pwrseq_out_decode u_dec (
        .state  (st),
        .ctl    (ctl),
        .status (mode_status)
    );

    assign core_clk_en   = ctl.core_en;
    assign periph_clk_en = ctl.periph_en;
    assign pwr_net_en    = ctl.net_en;
    assign pin_hold      = ctl.hold;
    assign sys_rst_out   = ctl.sysrst;

    // R7
    rst_matches_timer_chk: assert property (@(posedge clk) disable iff (rst)
        sys_rst_out == tmr_busy);
    // R5
    off_isolated_chk: assert property (@(posedge clk) disable iff (rst)
        mode_status == 2'd2 |-> (pin_hold && !pwr_net_en && !periph_clk_en && !core_clk_en));

endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_we = 0, ctl_idle = 0, ctl_stop = 0, arm_we = 0, arm_wdata = 0;
    logic irq_pend = 0, pin_rst_evt = 0, por_evt = 0;
    logic core_clk_en, periph_clk_en, pwr_net_en, pin_hold, sys_rst_out, arm_state;
    logic [1:0] mode_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_seq uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_idle(ctl_idle), .ctl_stop(ctl_stop),
        .arm_we(arm_we), .arm_wdata(arm_wdata), .irq_pend(irq_pend),
        .pin_rst_evt(pin_rst_evt), .por_evt(por_evt),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .pwr_net_en(pwr_net_en),
        .pin_hold(pin_hold), .sys_rst_out(sys_rst_out), .mode_status(mode_status),
        .arm_state(arm_state)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // outputs packed as {core, periph, net, hold, sysrst}
    function automatic int outs();
        return int'({core_clk_en, periph_clk_en, pwr_net_en, pin_hold, sys_rst_out});
    endfunction

    task automatic wr_ctl(input logic idle, input logic stop);
        ctl_we = 1; ctl_idle = idle; ctl_stop = stop;
        tick();
        ctl_we = 0; ctl_idle = 0; ctl_stop = 0;
    endtask

    task automatic wr_arm(input logic v);
        arm_we = 1; arm_wdata = v;
        tick();
        arm_we = 0; arm_wdata = 0;
    endtask

    task automatic recover_and_check(input string req);
        int n = 0;
        while (sys_rst_out && n < 40) begin
            n++;
            tick();
        end
        check({req, " reset length"}, n, 16);
        check({req, " status after"}, mode_status, 0);
        check({req, " arm cleared"}, arm_state, 0);
        check({req, " outputs after"}, outs(), 5'b11100);
    endtask

    task automatic t_reset();
        check("R1 outputs after rst", outs(), 5'b11100);
        check("R11 status after rst", mode_status, 0);
        check("R10 arm after rst", arm_state, 0);
    endtask

    task automatic t_idle_wake();
        wr_ctl(1, 0);
        check("R2 status idle", mode_status, 1);
        check("R2 outputs idle", outs(), 5'b01100);
        repeat (3) tick();
        check("R3 stays idle without irq", mode_status, 1);
        irq_pend = 1;
        tick();
        irq_pend = 0;
        check("R3 wake to run", mode_status, 0);
        check("R1 outputs back in run", outs(), 5'b11100);
    endtask

    task automatic t_stop_unarmed();
        wr_ctl(0, 1);
        check("R4 stop unarmed ignored", mode_status, 0);
        repeat (3) tick();
        check("R4 still run later", mode_status, 0);
        // arm written in the same cycle as stop: not yet armed
        arm_we = 1; arm_wdata = 1; ctl_we = 1; ctl_stop = 1;
        tick();
        arm_we = 0; arm_wdata = 0; ctl_we = 0; ctl_stop = 0;
        check("R4 same-cycle arm refused", mode_status, 0);
        check("R10 arm set by write", arm_state, 1);
        wr_arm(0);
        check("R10 arm cleared by write", arm_state, 0);
    endtask

    task automatic t_shutdown_pin();
        wr_arm(1);
        check("R10 arm set", arm_state, 1);
        wr_ctl(0, 1);
        check("R11 status off", mode_status, 2);
        check("R5 outputs off", outs(), 5'b00010);
        irq_pend = 1;
        repeat (4) tick();
        check("R6 irq ignored in off", mode_status, 2);
        check("R6 outputs still off", outs(), 5'b00010);
        irq_pend = 0;
        pin_rst_evt = 1;
        tick();
        pin_rst_evt = 0;
        check("R7 reset asserted", sys_rst_out, 1);
        check("R11 status during recovery", mode_status, 0);
        recover_and_check("R7 pin");
    endtask

    task automatic t_priority();
        wr_arm(1);
        wr_ctl(1, 1);
        check("R8 stop beats idle", mode_status, 2);
        por_evt = 1;
        tick();
        por_evt = 0;
        recover_and_check("R7 por");
    endtask

    task automatic t_pending();
        irq_pend = 1;
        wr_ctl(1, 0);
        check("R9 one idle cycle", mode_status, 1);
        tick();
        check("R9 leaves next edge", mode_status, 0);
        irq_pend = 0;
    endtask

    task automatic t_arm_persist();
        wr_arm(1);
        wr_ctl(1, 0);
        check("R10 arm held in idle", arm_state, 1);
        irq_pend = 1;
        tick();
        irq_pend = 0;
        check("R10 arm held after wake", arm_state, 1);
        wr_arm(0);
        wr_ctl(0, 1);
        check("R4 stop after disarm ignored", mode_status, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_idle_wake();
        t_stop_unarmed();
        t_shutdown_pin();
        t_priority();
        t_pending();
        t_arm_persist();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule